// File: doc/BRIEF.md
# SPI Dual-Format Register Access Slave

This block is an SPI slave for a device whose register map is split into two address spaces. A one-byte command reaches a small control space of 64 entries. A two-byte command reaches a larger 1024-entry space that holds further control registers and the packet buffers: transmit data from address 0x000 and receive data from 0x300. The first bit of each frame selects the format. Every access can be a read or a write. After a two-byte command, further data bytes in the same frame walk through consecutive addresses, so a host can move a whole buffer in one chip-select frame.

The SPI pins run in mode 0: the clock idles low and both sides sample on the rising edge. They are oversampled in the block's own clock domain, which must run at least twelve times faster than SCK, so that each SCK half period lasts six system clocks or more. The storage itself sits outside. The block issues one-cycle requests on a simple bus port and expects read data on the cycle after a read request. That data is shifted out on MISO in the byte slot that follows, MSB first.

Top module: `spireg_slave`

## Requirements
- R1: A short command (bit 7 = 0, address in bits 6:1, bit 0 = 1 for write) followed by one data byte produces exactly one bus write with `bus_long_o` = 0, the 6-bit address zero-extended on `bus_addr_o` and the data byte on `bus_wdata_o`.
- R2: A short command with bit 0 = 0 issues one bus read of that address with `bus_long_o` = 0. The byte returned is shifted out on MISO, MSB first, during the byte slot right after the command.
- R3: A short access is two bytes. Any further bytes in the same frame cause no bus request and read back as 0x00 on MISO.
- R4: A long command is 16 bits sent MSB first. Bit 15 is 1, bits 14:5 hold the 10-bit address and bit 4 = 1 marks a write. Bits 3:0 are ignored. A single long write of three bytes produces one bus write with `bus_long_o` = 1 at that address.
- R5: A long command with bit 4 = 0 returns the byte at its address on MISO in the third byte slot, MSB first.
- R6: In a long-write frame, each further data byte is written to the address after the previous one.
- R7: In a long-read frame, each further byte slot returns the byte at the next address.
- R8: During a long burst the address wraps from 0x3FF to 0x000.
- R9: Raising chip select in the middle of a byte discards that byte, so a partial write byte never reaches the bus. The next frame starts again with a command byte.
- R10: MISO is 0 whenever chip select is high. It is also 0 during command bytes and during the data slots of writes.
- R11: While reset is held and after it is released, `bus_req_o` and `miso_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 12x SCK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI clock, mode 0 |
| cs_ni | input | 1 | Chip select, active low, frames a transaction |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host, low when not selected |
| bus_req_o | output | 1 | One-cycle access request to register storage |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_long_o | output | 1 | 1 = long (1024-entry) space, 0 = short space |
| bus_addr_o | output | 10 | Access address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid the cycle after a read request |

## Verification
The hardest situations to reach are the ends of frames. One is a chip select that rises partway through a byte. Another is a long burst that crosses 0x3FF while fresh read data must be loaded between the last rising edge of one slot and the next falling edge. The bench's SPI master task takes a bit count as well as a byte count, so it can drop chip select after any number of bits, including partway through the command. It also runs bursts that start at 0x3FE and 0x3FF. A reference copy of the register contents, kept separately from the storage model, checks that nothing aborted leaked into storage and that wrapped reads return the right bytes.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int BYTE_W   = 8;
  localparam int SHORT_AW = 6;
  localparam int LONG_AW  = 10;

  typedef enum logic [1:0] {ST_CMD, ST_CMD2, ST_DATA, ST_IGNORE} frame_st_t;

  // first command bit picks the two-byte format
  function automatic logic cmd_is_long(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic logic [LONG_AW-1:0] short_addr(input logic [BYTE_W-1:0] b);
    return {{(LONG_AW-SHORT_AW){1'b0}}, b[SHORT_AW:1]};
  endfunction

  // upper seven address bits come from the first byte, lower three from the second
  function automatic logic [LONG_AW-1:0] long_addr(input logic [BYTE_W-2:0] hi,
                                                   input logic [2:0] lo_top);
    return {hi, lo_top};
  endfunction

  function automatic logic [LONG_AW-1:0] addr_next(input logic [LONG_AW-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= RST_VAL;
          else         stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= RST_VAL;
          else         stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spireg_rx_byte.sv
module spireg_rx_byte #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          sample_i,
  input  logic          bit_i,
  output logic          done_o,
  output logic [BW-1:0] byte_o
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [CW-1:0] cnt_q;
  logic [BW-2:0] sh_q;

  assign byte_o = {sh_q, bit_i};
  assign done_o = sample_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (sample_i) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= byte_o[BW-2:0];
    end
  end
endmodule

// File: rtl/spireg_tx_byte.sv
module spireg_tx_byte #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic [BW-1:0] data_i,
  input  logic          shift_i,
  output logic          bit_o
);
  logic [BW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_o <= 1'b0;
    end else if (clear_i) begin
      sh_q  <= '0;
      bit_o <= 1'b0;
    end else if (load_i) begin
      sh_q  <= data_i;
    end else if (shift_i) begin
      bit_o <= sh_q[BW-1];
      sh_q  <= {sh_q[BW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
  import spireg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               bus_req_o,
  output logic               bus_we_o,
  output logic               bus_long_o,
  output logic [LONG_AW-1:0] bus_addr_o,
  output logic [BYTE_W-1:0]  bus_wdata_o,
  input  logic [BYTE_W-1:0]  bus_rdata_i
);
  logic sck_s, csn_s, mosi_s, sck_d;
  logic frame_act, sck_rise, sck_fall;
  logic byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic rd_pend_q, miso_q;

  frame_st_t st_q;
  logic [BYTE_W-2:0]  cmd_hi_q;
  logic [LONG_AW-1:0] addr_q;
  logic wr_q, lng_q;

  spireg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, mosi_i}),
    .q_o   ({sck_s, csn_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end

  // named events used by the checker
  assign frame_act = !csn_s;
  assign sck_rise  = frame_act && sck_s && !sck_d;
  assign sck_fall  = frame_act && !sck_s && sck_d;

  spireg_rx_byte #(.BW(BYTE_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!frame_act),
    .sample_i(sck_rise),
    .bit_i   (mosi_s),
    .done_o  (byte_done),
    .byte_o  (rx_byte)
  );

  spireg_tx_byte #(.BW(BYTE_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!frame_act),
    .load_i (rd_pend_q),
    .data_i (bus_rdata_i),
    .shift_i(sck_fall),
    .bit_o  (miso_q)
  );

  assign miso_o = miso_q && !cs_ni;

  // frame sequencer: command decode, then data slots
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_CMD;
      cmd_hi_q    <= '0;
      addr_q      <= '0;
      wr_q        <= 1'b0;
      lng_q       <= 1'b0;
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_long_o  <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      rd_pend_q   <= 1'b0;
    end else begin
      bus_req_o <= 1'b0;
      rd_pend_q <= bus_req_o && !bus_we_o && frame_act;
      if (!frame_act) begin
        st_q <= ST_CMD;
      end else if (byte_done) begin
        case (st_q)
          ST_CMD: begin
            if (cmd_is_long(rx_byte)) begin
              cmd_hi_q <= rx_byte[BYTE_W-2:0];
              st_q     <= ST_CMD2;
            end else begin
              addr_q <= short_addr(rx_byte);
              wr_q   <= rx_byte[0];
              lng_q  <= 1'b0;
              st_q   <= ST_DATA;
              if (!rx_byte[0]) begin
                bus_req_o  <= 1'b1;
                bus_we_o   <= 1'b0;
                bus_long_o <= 1'b0;
                bus_addr_o <= short_addr(rx_byte);
              end
            end
          end
          ST_CMD2: begin
            addr_q <= long_addr(cmd_hi_q, rx_byte[BYTE_W-1:BYTE_W-3]);
            wr_q   <= rx_byte[4];
            lng_q  <= 1'b1;
            st_q   <= ST_DATA;
            if (!rx_byte[4]) begin
              bus_req_o  <= 1'b1;
              bus_we_o   <= 1'b0;
              bus_long_o <= 1'b1;
              bus_addr_o <= long_addr(cmd_hi_q, rx_byte[BYTE_W-1:BYTE_W-3]);
            end
          end
          ST_DATA: begin
            if (wr_q) begin
              bus_req_o   <= 1'b1;
              bus_we_o    <= 1'b1;
              bus_long_o  <= lng_q;
              bus_addr_o  <= addr_q;
              bus_wdata_o <= rx_byte;
            end
            if (lng_q) begin
              addr_q <= addr_next(addr_q);
              if (!wr_q) begin
                bus_req_o  <= 1'b1;
                bus_we_o   <= 1'b0;
                bus_long_o <= 1'b1;
                bus_addr_o <= addr_next(addr_q);
              end
            end else begin
              st_q <= ST_IGNORE;
            end
          end
          default: st_q <= ST_IGNORE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spireg_slave_chk.sv
module spireg_slave_chk
  import spireg_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_act,
  input logic               byte_done,
  input logic               bus_req_o,
  input logic               bus_long_o,
  input logic [LONG_AW-1:0] bus_addr_o,
  input logic               miso_o
);
  localparam logic [LONG_AW-1:0] TOP_ADDR = {LONG_AW{1'b1}};

  logic               short_seen_q;
  logic               have_last_q;
  logic [LONG_AW-1:0] last_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      short_seen_q <= 1'b0;
      have_last_q  <= 1'b0;
      last_addr_q  <= '0;
    end else if (!frame_act) begin
      short_seen_q <= 1'b0;
      have_last_q  <= 1'b0;
    end else if (bus_req_o) begin
      if (!bus_long_o) short_seen_q <= 1'b1;
      else begin
        have_last_q <= 1'b1;
        last_addr_q <= bus_addr_o;
      end
    end
  end

  // R1: every bus access follows a completed byte
  p_req_after_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> $past(byte_done));

  // R3: a short frame makes at most one access
  p_short_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_long_o) |-> !short_seen_q);

  // R6 / R7: successive long accesses in a frame step by one
  p_burst_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_long_o && have_last_q && last_addr_q != TOP_ADDR)
      |-> bus_addr_o == last_addr_q + 1'b1);

  // R8: the top of the long space wraps to zero
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_long_o && have_last_q && last_addr_q == TOP_ADDR)
      |-> bus_addr_o == '0);

  // R9: no access once the frame has ended
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_act |=> !bus_req_o);

  // R10: MISO low outside a frame
  p_idle_miso_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_act |-> !miso_o);
endmodule

bind spireg_slave spireg_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_act (frame_act),
  .byte_done (byte_done),
  .bus_req_o (bus_req_o),
  .bus_long_o(bus_long_o),
  .bus_addr_o(bus_addr_o),
  .miso_o    (miso_o)
);

// File: tb/spireg_slave_tb.sv
module spireg_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, mosi;
  logic miso, req, we, lng;
  logic [9:0] addr;
  logic [7:0] wdata, rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  spireg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .bus_req_o(req), .bus_we_o(we), .bus_long_o(lng),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata)
  );

  int nchk = 0;
  int nfail = 0;

  logic [7:0] smem [64];
  logic [7:0] lmem [1024];
  logic [7:0] ref_s [64];
  logic [7:0] ref_l [1024];

  logic [18:0] exp_q [$];
  string       tag_q [$];

  logic [7:0] tx_b [0:15];
  logic [7:0] rx_b [0:15];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // storage model on the bus port: read data one cycle after the request
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++)   smem[i] <= 8'(i * 3 + 1);
      for (int i = 0; i < 1024; i++) lmem[i] <= 8'(i) ^ 8'hC3;
      rdata <= 8'h00;
    end else if (req) begin
      if (we) begin
        if (lng) lmem[addr] <= wdata;
        else     smem[addr[5:0]] <= wdata;
      end else begin
        rdata <= lng ? lmem[addr] : smem[addr[5:0]];
      end
    end
  end

  // scoreboard monitor for bus writes
  always @(negedge clk) begin
    if (rst_n && req && we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected bus write", int'({lng, addr, wdata}), 0);
      end else begin
        logic [18:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({lng, addr, wdata} == e, t, "bus write {long,addr,data}",
            int'({lng, addr, wdata}), int'(e));
      end
    end
  end

  task automatic push_wr(input bit l, input logic [9:0] a, input logic [7:0] d,
                         input string t);
    exp_q.push_back({l, a, d});
    tag_q.push_back(t);
    if (l) ref_l[a] = d;
    else   ref_s[a[5:0]] = d;
  endtask

  // SPI mode-0 master: nb whole bytes then xbits more bits, then deselect
  task automatic xfer(input int nb, input int xbits);
    int total;
    total = nb * 8 + xbits;
    for (int i = 0; i < 16; i++) rx_b[i] = 8'h00;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < total; k++) begin
      mosi = tx_b[k/8][7 - (k % 8)];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      rx_b[k/8][7 - (k % 8)] = miso;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(miso == 1'b0, "R10", "miso after deselect", int'(miso), 0);
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic sb_empty(input string t);
    chk(exp_q.size() == 0, t, "writes still pending", exp_q.size(), 0);
  endtask

  function automatic logic [15:0] lcmd(input logic [9:0] a, input bit w);
    return {1'b1, a, w, 4'b1010};
  endfunction

  task automatic short_wr(input logic [5:0] a, input logic [7:0] d);
    tx_b[0] = {1'b0, a, 1'b1};
    tx_b[1] = d;
    push_wr(1'b0, {4'b0, a}, d, "R1");
    xfer(2, 0);
    chk(rx_b[0] == 8'h00 && rx_b[1] == 8'h00, "R10", "miso during short write",
        int'({rx_b[0], rx_b[1]}), 0);
    sb_empty("R1");
  endtask

  task automatic short_rd(input logic [5:0] a, input int extra);
    tx_b[0] = {1'b0, a, 1'b0};
    for (int i = 1; i < 16; i++) tx_b[i] = 8'h5A;
    xfer(2 + extra, 0);
    chk(rx_b[0] == 8'h00, "R10", "miso during command", int'(rx_b[0]), 0);
    chk(rx_b[1] == ref_s[a], "R2", "short read data", int'(rx_b[1]), int'(ref_s[a]));
    for (int i = 0; i < extra; i++)
      chk(rx_b[2+i] == 8'h00, "R3", "extra byte after short read", int'(rx_b[2+i]), 0);
  endtask

  task automatic long_wr(input logic [9:0] a, input int n, input logic [7:0] seed,
                         input string t);
    logic [15:0] c;
    c = lcmd(a, 1'b1);
    tx_b[0] = c[15:8];
    tx_b[1] = c[7:0];
    for (int i = 0; i < n; i++) begin
      tx_b[2+i] = seed + 8'(i * 17);
      push_wr(1'b1, a + 10'(i), tx_b[2+i], t);
    end
    xfer(2 + n, 0);
    sb_empty(t);
  endtask

  task automatic long_rd(input logic [9:0] a, input int n, input string t);
    logic [15:0] c;
    c = lcmd(a, 1'b0);
    tx_b[0] = c[15:8];
    tx_b[1] = c[7:0];
    for (int i = 0; i < n; i++) tx_b[2+i] = 8'hFF;
    xfer(2 + n, 0);
    chk(rx_b[0] == 8'h00 && rx_b[1] == 8'h00, "R10", "miso during long command",
        int'({rx_b[0], rx_b[1]}), 0);
    for (int i = 0; i < n; i++) begin
      logic [9:0] ai;
      ai = a + 10'(i);
      chk(rx_b[2+i] == ref_l[ai], t, "long read data", int'(rx_b[2+i]), int'(ref_l[ai]));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired: actual 0x%0h expected 0x%0h", WATCHDOG, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++)   ref_s[i] = 8'(i * 3 + 1);
    for (int i = 0; i < 1024; i++) ref_l[i] = 8'(i) ^ 8'hC3;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    chk(req == 1'b0 && miso == 1'b0, "R11", "outputs in reset", int'({req, miso}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(req == 1'b0 && miso == 1'b0, "R11", "outputs after reset", int'({req, miso}), 0);

    // R1, R2: short write then read back, plus an untouched entry
    short_wr(6'h15, 8'hA5);
    short_rd(6'h15, 0);
    short_rd(6'h3F, 0);

    // R3: extra bytes after a short access
    tx_b[0] = {1'b0, 6'h03, 1'b1};
    tx_b[1] = 8'h3C; tx_b[2] = 8'h11; tx_b[3] = 8'h22;
    push_wr(1'b0, 10'h003, 8'h3C, "R3");
    xfer(4, 0);
    sb_empty("R3");
    short_rd(6'h03, 2);

    // R4, R5: single long write and read, ignored low nibble
    long_wr(10'h123, 1, 8'h5A, "R4");
    long_rd(10'h123, 1, "R5");

    // R6, R7: buffer bursts at the transmit and receive areas
    long_wr(10'h000, 4, 8'h11, "R6");
    long_rd(10'h000, 4, "R7");
    long_wr(10'h300, 5, 8'h80, "R6");
    long_rd(10'h300, 5, "R7");

    // R8: crossing the top of the long space
    long_wr(10'h3FE, 3, 8'h07, "R8");
    long_rd(10'h3FF, 2, "R8");
    long_rd(10'h3FD, 4, "R8");

    // R9: abort in the data byte of a short write
    tx_b[0] = {1'b0, 6'h05, 1'b1};
    tx_b[1] = 8'hFF;
    xfer(1, 4);
    sb_empty("R9");
    short_rd(6'h05, 0);

    // R9: abort inside the long command, next frame decodes afresh
    tx_b[0] = 8'hA4;
    xfer(0, 3);
    short_rd(6'h15, 0);

    // R9: abort after the first byte of a long burst
    begin
      logic [15:0] c;
      c = lcmd(10'h010, 1'b1);
      tx_b[0] = c[15:8]; tx_b[1] = c[7:0];
      tx_b[2] = 8'h9E; tx_b[3] = 8'hE9;
      push_wr(1'b1, 10'h010, 8'h9E, "R9");
      xfer(3, 5);
      sb_empty("R9");
      long_rd(10'h010, 2, "R9");
    end

    finish_run();
  end
endmodule